// File: doc/BRIEF.md
# Sequential Radix-4 Booth Multiplier

This block multiplies two signed two's complement operands over several clock cycles. It keeps one double-width product register and updates it in place. It also keeps one extra bit to the right of the least significant product bit. Each iteration adds a recoded multiple of the multiplicand into the upper part of the register and then shifts the whole register right arithmetically. In the default mode, an overlapping three-bit window of the multiplier picks the multiple. This retires two multiplier bits per clock. A second mode uses the classic two-bit Booth pair and retires one bit per clock.

A caller drives the operands and the mode, then pulses `start` while the block is idle. `busy` stays high while the iterations run. `done` pulses for one cycle when the final shift lands. At that moment the signed product appears on `product` and stays there until the next multiplication completes. When the operand width is odd, both operands are sign-extended by one bit inside the block, so the recoding always works on an even width.

Top module: `booth_seq_mul`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `product` are all zero.
- R2: A `start` seen while `busy` and `done` are low loads the operands and `one_bit_mode`. `busy` is high in the following cycle.
- R3: With `one_bit_mode` = 0, the window {P[1], P[0], P[-1]} selects the multiple added each step, then the register shifts right by two:
  - 000 and 111 select 0.
  - 001 and 010 select +M.
  - 011 selects +2M.
  - 100 selects -2M.
  - 101 and 110 select -M.
  
  The final `product` equals the signed product of `mcand` and `mplier`, taken modulo 2^(2·WIDTH). This holds for the most negative operands and for alternating-bit multipliers.
- R4: With `one_bit_mode` = 1, the pair {P[0], P[-1]} selects the action, and each step shifts right by one:
  - 01 adds M.
  - 10 subtracts M.
  - 00 and 11 add nothing.
  
  The final `product` equals the same signed product as in R3.
- R5: `done` goes high exactly E/2 cycles after the accepting clock edge with `one_bit_mode` = 0, and exactly E cycles after it with `one_bit_mode` = 1. Here E is WIDTH rounded up to even.
- R6: `done` is high for one cycle only and is never high together with `busy`.
- R7: A `start` that arrives while `busy` is high has no effect. This includes a `start` in the final busy cycle. The running result is unchanged, and no second run begins.
- R8: `product` changes only at a completion and keeps its value while idle and during the next run.
- R9: For an odd WIDTH, the operands are sign-extended by one bit, and the product is correct in both modes for every operand pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a multiplication |
| one_bit_mode | input | 1 | 1 selects the one-bit-per-cycle pair recoding |
| mcand | input | WIDTH | Signed multiplicand |
| mplier | input | WIDTH | Signed multiplier |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | 2*WIDTH | Signed product |

## Verification
The critical coincidence is a new `start` landing on the same clock edge as the final add-and-shift of the running multiplication. At that edge `busy` is still high, so the request must be dropped. The bench provokes this by raising `start` with different operands exactly in the last busy cycle. It then judges the outcome in three ways:
- the completion carries the first operands' product;
- `busy` stays low afterwards;
- no unexpected `done` appears with an empty scoreboard queue.

// File: rtl/booth_pkg.sv
package booth_pkg;

  // Multiple of the multiplicand chosen by the recoder
  typedef enum logic [2:0] {
    MUL_ZERO = 3'd0,
    MUL_POS1 = 3'd1,
    MUL_POS2 = 3'd2,
    MUL_NEG1 = 3'd3,
    MUL_NEG2 = 3'd4
  } mult_e;

  // Three-bit overlapping window {P1, P0, Pm1}
  function automatic mult_e recode_r4(input logic [2:0] win);
    case (win)
      3'b001, 3'b010: return MUL_POS1;
      3'b011:         return MUL_POS2;
      3'b100:         return MUL_NEG2;
      3'b101, 3'b110: return MUL_NEG1;
      default:        return MUL_ZERO;
    endcase
  endfunction

  // Two-bit pair {P0, Pm1}
  function automatic mult_e recode_r2(input logic [1:0] pair);
    case (pair)
      2'b01:   return MUL_POS1;
      2'b10:   return MUL_NEG1;
      default: return MUL_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_pkg::*;
(
  input  logic       one_bit,
  input  logic [2:0] win,
  output mult_e      sel
);
  always_comb begin
    if (one_bit) sel = recode_r2(win[1:0]);
    else         sel = recode_r4(win);
  end
endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
  import booth_pkg::*;
#(
  parameter int EW = 16
) (
  input  logic [EW-1:0] mcand,
  input  mult_e         sel,
  output logic [EW+1:0] pp
);
  localparam int AW = EW + 2;

  logic [AW-1:0] m1, m2;

  // Sign-extended multiplicand and its left-shifted double
  assign m1 = {{2{mcand[EW-1]}}, mcand};
  assign m2 = {mcand[EW-1], mcand, 1'b0};

  always_comb begin
    case (sel)
      MUL_POS1: pp = m1;
      MUL_POS2: pp = m2;
      MUL_NEG1: pp = ~m1 + AW'(1);
      MUL_NEG2: pp = ~m2 + AW'(1);
      default:  pp = '0;
    endcase
  end
endmodule

// File: rtl/booth_shift_step.sv
module booth_shift_step #(
  parameter int EW = 16
) (
  input  logic          one_bit,
  input  logic [EW+1:0] acc,
  input  logic [EW-1:0] low,
  input  logic          pm1,
  input  logic [EW+1:0] pp,
  output logic [EW+1:0] acc_n,
  output logic [EW-1:0] low_n,
  output logic          pm1_n
);
  localparam int AW = EW + 2;

  logic [AW-1:0] sum;
  assign sum = acc + pp;

  always_comb begin
    if (one_bit) begin
      acc_n = {sum[AW-1], sum[AW-1:1]};
      low_n = {sum[0], low[EW-1:1]};
      pm1_n = low[0];
    end else begin
      acc_n = {{2{sum[AW-1]}}, sum[AW-1:2]};
      low_n = {sum[1:0], low[EW-1:2]};
      pm1_n = low[1];
    end
  end
endmodule

// File: rtl/booth_seq_mul.sv
module booth_seq_mul
  import booth_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               one_bit_mode,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  localparam int EW   = WIDTH + (WIDTH % 2);
  localparam int AW   = EW + 2;
  localparam int IT4  = EW / 2;
  localparam int IT2  = EW;
  localparam int CW   = $clog2(IT2 + 1);
  localparam int HIGH = 2 * WIDTH - EW;

  logic [EW-1:0] mc_ext, mp_ext;

  generate
    if (WIDTH % 2 == 1) begin : g_odd
      assign mc_ext = {mcand[WIDTH-1], mcand};
      assign mp_ext = {mplier[WIDTH-1], mplier};
    end else begin : g_even
      assign mc_ext = mcand;
      assign mp_ext = mplier;
    end
  endgenerate

  logic [EW-1:0] mcand_q;
  logic [AW-1:0] acc_q, acc_n, pp;
  logic [EW-1:0] low_q, low_n;
  logic          pm1_q, pm1_n;
  logic          mode_q;
  logic [CW-1:0] cnt_q;
  mult_e         sel;

  // Named events for the checker
  logic accept, last_step;
  assign accept    = start && !busy;
  assign last_step = busy && (cnt_q == '0);

  booth_recoder u_rec (
    .one_bit (mode_q),
    .win     ({low_q[1], low_q[0], pm1_q}),
    .sel     (sel)
  );

  booth_pp_gen #(.EW(EW)) u_pp (
    .mcand (mcand_q),
    .sel   (sel),
    .pp    (pp)
  );

  booth_shift_step #(.EW(EW)) u_step (
    .one_bit (mode_q),
    .acc     (acc_q),
    .low     (low_q),
    .pm1     (pm1_q),
    .pp      (pp),
    .acc_n   (acc_n),
    .low_n   (low_n),
    .pm1_n   (pm1_n)
  );

  // Final product drops the guard bits
  logic [2*WIDTH-1:0] prod_n;
  assign prod_n = {acc_n[HIGH-1:0], low_n};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      product <= '0;
      mcand_q <= '0;
      acc_q   <= '0;
      low_q   <= '0;
      pm1_q   <= 1'b0;
      mode_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        mcand_q <= mc_ext;
        acc_q   <= '0;
        low_q   <= mp_ext;
        pm1_q   <= 1'b0;
        mode_q  <= one_bit_mode;
        cnt_q   <= one_bit_mode ? CW'(IT2 - 1) : CW'(IT4 - 1);
        busy    <= 1'b1;
      end else if (busy) begin
        acc_q <= acc_n;
        low_q <= low_n;
        pm1_q <= pm1_n;
        cnt_q <= cnt_q - CW'(1);
        if (last_step) begin
          busy    <= 1'b0;
          done    <= 1'b1;
          product <= prod_n;
        end
      end
    end
  end

endmodule

// File: rtl/booth_seq_mul_chk.sv
module booth_seq_mul_chk #(
  parameter int WIDTH = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               accept,
  input logic               last_step,
  input logic               busy,
  input logic               done,
  input logic               mode_q,
  input logic [2*WIDTH-1:0] product
);
  localparam int EW = WIDTH + (WIDTH % 2);
  localparam int CW = $clog2(EW + 1);

  logic [CW-1:0] steps_q;
  always_ff @(posedge clk) begin
    if (!rst_n)      steps_q <= '0;
    else if (accept) steps_q <= '0;
    else if (busy)   steps_q <= steps_q + CW'(1);
  end

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R5
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps_q == (mode_q ? CW'(EW) : CW'(EW / 2))));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R7
  late_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> !busy);

  // R8
  product_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_step |=> $stable(product));

endmodule

bind booth_seq_mul booth_seq_mul_chk #(.WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .last_step (last_step),
  .busy      (busy),
  .done      (done),
  .mode_q    (mode_q),
  .product   (product)
);

// File: tb/booth_seq_mul_tb_top.sv
module booth_seq_mul_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_cmp = 0;
  int n_bad = 0;

  // 16-bit instance
  logic        st16 = 0, m16 = 0, busy16, done16;
  logic [15:0] mc16 = 0, mp16 = 0;
  logic [31:0] pr16;

  booth_seq_mul #(.WIDTH(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(st16), .one_bit_mode(m16),
    .mcand(mc16), .mplier(mp16), .busy(busy16), .done(done16), .product(pr16)
  );

  // odd-width instance
  logic       st5 = 0, m5 = 0, busy5, done5;
  logic [4:0] mc5 = 0, mp5 = 0;
  logic [9:0] pr5;

  booth_seq_mul #(.WIDTH(5)) dut_odd_i (
    .clk(clk), .rst_n(rst_n), .start(st5), .one_bit_mode(m5),
    .mcand(mc5), .mplier(mp5), .busy(busy5), .done(done5), .product(pr5)
  );

  typedef struct {
    longint expv;
    longint t0;
    longint iters;
    string  tag;
  } item_t;

  item_t q16[$];
  item_t q5[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic longint sx(input longint v, input int n);
    return (v >= (longint'(1) << (n - 1))) ? v - (longint'(1) << n) : v;
  endfunction

  function automatic longint ref_mul(input longint a, input longint b, input int n);
    return (sx(a, n) * sx(b, n)) & ((longint'(1) << (2 * n)) - 1);
  endfunction

  // Monitors: pop and compare on each completion
  always @(negedge clk) begin
    item_t it;
    if (rst_n && done16) begin
      if (q16.size() == 0) check(0, "R7", "unexpected done (16)", 1, 0);
      else begin
        it = q16.pop_front();
        check(longint'(pr16) == it.expv, it.tag, "product16", longint'(pr16), it.expv);
        check(cyc - it.t0 == it.iters, "R5", "latency16", cyc - it.t0, it.iters);
        check(busy16 == 1'b0, "R6", "busy with done16", longint'(busy16), 0);
      end
    end
  end

  always @(negedge clk) begin
    item_t it;
    if (rst_n && done5) begin
      if (q5.size() == 0) check(0, "R7", "unexpected done (5)", 1, 0);
      else begin
        it = q5.pop_front();
        check(longint'(pr5) == it.expv, it.tag, "product5", longint'(pr5), it.expv);
        check(cyc - it.t0 == it.iters, "R5", "latency5", cyc - it.t0, it.iters);
      end
    end
  end

  task automatic drive16(input logic [15:0] a, input logic [15:0] b,
                         input logic mode, input string tag);
    item_t it;
    while (busy16 || done16) @(negedge clk);
    mc16 = a; mp16 = b; m16 = mode; st16 = 1'b1;
    it.expv = ref_mul(a, b, 16); it.t0 = cyc + 1;
    it.iters = mode ? 16 : 8; it.tag = tag;
    q16.push_back(it);
    @(negedge clk);
    st16 = 1'b0;
    check(busy16 == 1'b1, "R2", "busy after start16", longint'(busy16), 1);
  endtask

  task automatic drive5(input logic [4:0] a, input logic [4:0] b, input logic mode);
    item_t it;
    while (busy5 || done5) @(negedge clk);
    mc5 = a; mp5 = b; m5 = mode; st5 = 1'b1;
    it.expv = ref_mul(a, b, 5); it.t0 = cyc + 1;
    it.iters = mode ? 6 : 3; it.tag = "R9";
    q5.push_back(it);
    @(negedge clk);
    st5 = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy16 || done16 || busy5 || done5 || q16.size() != 0 || q5.size() != 0)
      @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WD", "watchdog expired", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    longint t0;
    logic [31:0] held;

    // R1 reset state
    repeat (3) @(negedge clk);
    check(busy16 == 0 && done16 == 0 && pr16 == 0, "R1", "reset outputs16", longint'(pr16), 0);
    check(busy5 == 0 && done5 == 0 && pr5 == 0, "R1", "reset outputs5", longint'(pr5), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy16 == 0 && done16 == 0 && pr16 == 0, "R1", "after release16", longint'(pr16), 0);

    // Worked example and corners, window recoding
    drive16(16'd11, 16'd14, 1'b0, "R3");
    drive16(16'd11, 16'd14, 1'b1, "R4");
    drive16(16'h8000, 16'h8000, 1'b0, "R3");
    drive16(16'h8000, 16'h8000, 1'b1, "R4");
    drive16(16'h8000, 16'h7FFF, 1'b0, "R3");
    drive16(16'h7FFF, 16'h8000, 1'b1, "R4");
    drive16(16'h1234, 16'hAAAA, 1'b0, "R3");
    drive16(16'hFEDC, 16'h5555, 1'b0, "R3");
    drive16(16'h1234, 16'hAAAA, 1'b1, "R4");
    drive16(16'hFEDC, 16'h5555, 1'b1, "R4");
    drive16(16'h0000, 16'hFFFF, 1'b0, "R3");
    drive16(16'hFFFF, 16'hFFFF, 1'b1, "R4");
    for (int k = 0; k < 200; k++) begin
      drive16(16'($urandom), 16'($urandom), 1'b0, "R3");
      drive16(16'($urandom), 16'($urandom), 1'b1, "R4");
    end
    wait_idle();

    // R8 hold while idle and through the next run
    held = pr16;
    repeat (6) @(negedge clk);
    check(pr16 == held && done16 == 0, "R8", "idle hold", longint'(pr16), longint'(held));
    drive16(16'd3, 16'd5, 1'b0, "R3");
    @(negedge clk);
    check(pr16 == held, "R8", "hold during run", longint'(pr16), longint'(held));
    wait_idle();

    // R7 start while busy, mid-run and in the final busy cycle
    mc16 = 16'd1234; mp16 = 16'hFFB3; m16 = 1'b0; st16 = 1'b1;
    t0 = cyc + 1;
    q16.push_back('{ref_mul(16'd1234, 16'hFFB3, 16), t0, 8, "R7"});
    @(negedge clk);
    st16 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    mc16 = 16'd999; mp16 = 16'd7; m16 = 1'b1; st16 = 1'b1;
    @(negedge clk);
    st16 = 1'b0;
    while (cyc < t0 + 7) @(negedge clk);
    mc16 = 16'd42; mp16 = 16'd42; st16 = 1'b1;
    @(negedge clk);
    st16 = 1'b0;
    check(busy16 == 0, "R7", "late start began a run", longint'(busy16), 0);
    @(negedge clk);
    check(busy16 == 0 && done16 == 0, "R7", "no second run", longint'(busy16), 0);
    wait_idle();

    // R9 odd width, every pair in both modes
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) begin
        drive5(5'(i), 5'(j), 1'b0);
        drive5(5'(i), 5'(j), 1'b1);
      end
    wait_idle();

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule